// File: doc/BRIEF.md
# Banked Workgroup Scratch Memory

This block is the on-chip scratch store that the threads of one workgroup share. It holds 64 KB, organised as 32 banks, each bank one dword wide and 512 rows deep. A request carries 16 lanes. Every lane has a dword address, a write flag and a write dword. All 16 lanes are presented together in one cycle.

Lanes that fall in different banks are served in the same cycle. Lanes that fall in one bank but on different rows conflict, and they are spread over extra cycles. Lanes that name exactly the same address never conflict. Every read among them gets the one word read from the bank. Every lane of a request returns the word its address held before the request. The per-lane results come out together with a one-cycle valid strobe. While a conflicting request is being replayed, the block drops its ready output and ignores new requests.

Top module: `shared_scratch_mem`

## Requirements
- R1: The storage is 32 banks of 512 dwords (64 KB). For a dword address, bits [4:0] select the bank and bits [13:5] select the row. A dword written at any address, including the highest row, reads back unchanged.
- R2: A request whose 16 lanes all hit different banks is served in one cycle. ready_o stays high, and rsp_valid_o rises in the cycle right after the accepting edge.
- R3: In each cycle, each bank serves the address of its lowest-numbered pending lane. A request takes as many cycles as the largest number of distinct rows addressed within any single bank. For example, 16 lanes at a stride of 32 dwords take 16 cycles, and a stride of 16 takes 8 cycles.
- R4: Lanes that read the same address are served together in one cycle, and all of them receive that word.
- R5: When several lanes of one request write the same address, the data of the highest-numbered of those lanes is stored.
- R6: Every lane's result is the word its address held before the request, even when another lane of the same request writes that address.
- R7: rsp_valid_o is a single-cycle strobe in the cycle after the last lane is served. rsp_rdata_o carries all 16 lane results in that cycle.
- R8: ready_o is low from the first replay cycle until the last lane is served. A request presented while ready_o is low has no effect on memory contents.
- R9: While reset is asserted and right after it, ready_o is high and rsp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A request is presented; it is taken when ready_o is high |
| ready_o | output | 1 | Block idle and able to take a request |
| req_we_i | input | 16 | Per-lane write flag; bit n belongs to lane n |
| req_addr_i | input | 224 | Per-lane dword address; lane n occupies bits [14n+13:14n] |
| req_wdata_i | input | 512 | Per-lane write dword; lane n occupies bits [32n+31:32n] |
| rsp_valid_o | output | 1 | One-cycle strobe: all lane results are present |
| rsp_rdata_o | output | 512 | Per-lane result dword; lane n occupies bits [32n+31:32n] |

## Verification
The assertions take for granted that a request changes the state only when ready_o is high. They treat req_valid_i as a plain level, with no need to hold it. From that they derive that ready_o only falls after a presented request, that a result never appears while ready_o is low, and that a replay never lasts longer than one cycle per lane. The stimulus presents each request for exactly one accepting edge and then withdraws it. It presents a request during replay only on purpose, for one cycle early in a long replay, and always withdraws it before ready_o returns, so no request is ever taken by accident.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int unsigned DEF_LANES  = 16;
  localparam int unsigned DEF_BANKS  = 32;
  localparam int unsigned DEF_ROWS   = 512;
  localparam int unsigned DEF_DATA_W = 32;
endpackage

// File: rtl/ssm_bank.sv
module ssm_bank #(
  parameter int unsigned ROWS   = ssm_pkg::DEF_ROWS,
  parameter int unsigned DATA_W = ssm_pkg::DEF_DATA_W,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [ROWS];

  // read is combinational: returns the pre-edge word even when written at this edge
  assign rdata_o = mem_q[row_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[row_i] <= wdata_i;
  end
endmodule

// File: rtl/ssm_arbiter.sv
module ssm_arbiter #(
  parameter int unsigned LANES  = ssm_pkg::DEF_LANES,
  parameter int unsigned BANKS  = ssm_pkg::DEF_BANKS,
  parameter int unsigned ROWS   = ssm_pkg::DEF_ROWS,
  parameter int unsigned DATA_W = ssm_pkg::DEF_DATA_W,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned ROW_W  = $clog2(ROWS)
) (
  input  logic [LANES-1:0]             pend_i,
  input  logic [LANES-1:0]             we_i,
  input  logic [LANES-1:0][BANK_W-1:0] bank_i,
  input  logic [LANES-1:0][ROW_W-1:0]  row_i,
  input  logic [LANES-1:0][DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]             served_o,
  output logic [BANKS-1:0][ROW_W-1:0]  lead_row_o,
  output logic [BANKS-1:0]             bank_we_o,
  output logic [BANKS-1:0][DATA_W-1:0] bank_wdata_o
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    // leader: lowest pending lane of this bank (descending scan, last hit wins)
    always_comb begin
      lead_row_o[b] = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pend_i[l] && bank_i[l] == BANK_W'(b)) lead_row_o[b] = row_i[l];
      end
    end

    // write: highest served writer of this bank wins (ascending scan)
    always_comb begin
      bank_we_o[b]    = 1'b0;
      bank_wdata_o[b] = '0;
      for (int l = 0; l < LANES; l++) begin
        if (served_o[l] && we_i[l] && bank_i[l] == BANK_W'(b)) begin
          bank_we_o[b]    = 1'b1;
          bank_wdata_o[b] = wdata_i[l];
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign served_o[l] = pend_i[l] && (row_i[l] == lead_row_o[bank_i[l]]);
  end
endmodule

// File: rtl/shared_scratch_mem.sv
module shared_scratch_mem #(
  parameter int unsigned LANES  = ssm_pkg::DEF_LANES,
  parameter int unsigned BANKS  = ssm_pkg::DEF_BANKS,
  parameter int unsigned ROWS   = ssm_pkg::DEF_ROWS,
  parameter int unsigned DATA_W = ssm_pkg::DEF_DATA_W,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned ADDR_W = BANK_W + ROW_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      ready_o,
  input  logic [LANES-1:0]          req_we_i,
  input  logic [LANES*ADDR_W-1:0]   req_addr_i,
  input  logic [LANES*DATA_W-1:0]   req_wdata_i,
  output logic                      rsp_valid_o,
  output logic [LANES*DATA_W-1:0]   rsp_rdata_o
);
  logic                             busy_q, rsp_valid_q, accept;
  logic [LANES-1:0]                 pend_q, we_q, pend_s, we_s, served, rem;
  logic [LANES-1:0][BANK_W-1:0]     bank_in, bank_q, bank_s;
  logic [LANES-1:0][ROW_W-1:0]      row_in, row_q, row_s;
  logic [LANES-1:0][DATA_W-1:0]     wd_in, wd_q, wd_s, lane_rd, rdata_q;
  logic [BANKS-1:0][ROW_W-1:0]      lead_row;
  logic [BANKS-1:0]                 bank_we;
  logic [BANKS-1:0][DATA_W-1:0]     bank_wd, bank_rd;

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign bank_in[l] = req_addr_i[l*ADDR_W +: BANK_W];
    assign row_in[l]  = req_addr_i[l*ADDR_W + BANK_W +: ROW_W];
    assign wd_in[l]   = req_wdata_i[l*DATA_W +: DATA_W];
    assign rsp_rdata_o[l*DATA_W +: DATA_W] = rdata_q[l];
    assign lane_rd[l] = bank_rd[bank_s[l]];
  end

  assign accept  = req_valid_i & ~busy_q;
  assign ready_o = ~busy_q;

  // first service cycle runs straight from the inputs; replays from the latched copy
  assign pend_s = busy_q ? pend_q : {LANES{accept}};
  assign we_s   = busy_q ? we_q   : req_we_i;
  assign bank_s = busy_q ? bank_q : bank_in;
  assign row_s  = busy_q ? row_q  : row_in;
  assign wd_s   = busy_q ? wd_q   : wd_in;
  assign rem    = pend_s & ~served;

  ssm_arbiter #(
    .LANES(LANES), .BANKS(BANKS), .ROWS(ROWS), .DATA_W(DATA_W)
  ) u_arb (
    .pend_i      (pend_s),
    .we_i        (we_s),
    .bank_i      (bank_s),
    .row_i       (row_s),
    .wdata_i     (wd_s),
    .served_o    (served),
    .lead_row_o  (lead_row),
    .bank_we_o   (bank_we),
    .bank_wdata_o(bank_wd)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_mem
    ssm_bank #(.ROWS(ROWS), .DATA_W(DATA_W)) u_bank (
      .clk_i  (clk_i),
      .we_i   (bank_we[b]),
      .row_i  (lead_row[b]),
      .wdata_i(bank_wd[b]),
      .rdata_o(bank_rd[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      pend_q      <= '0;
      we_q        <= '0;
      bank_q      <= '0;
      row_q       <= '0;
      wd_q        <= '0;
      rdata_q     <= '0;
    end else begin
      if (accept) begin
        we_q   <= req_we_i;
        bank_q <= bank_in;
        row_q  <= row_in;
        wd_q   <= wd_in;
      end
      if (accept || busy_q) begin
        pend_q <= rem;
        busy_q <= |rem;
      end
      rsp_valid_q <= (accept || busy_q) && ~|rem;
      for (int l = 0; l < LANES; l++) begin
        if (served[l]) rdata_q[l] <= lane_rd[l];
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker #(
  parameter int unsigned LANES = ssm_pkg::DEF_LANES
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic ready_o,
  input logic rsp_valid_o
);
  logic [$clog2(LANES+1)-1:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_cnt_q <= '0;
    else if (ready_o)  busy_cnt_q <= '0;
    else               busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  AST_VALID_AFTER_SERVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!ready_o || req_valid_i)); // R7

  AST_IDLE_AT_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ready_o); // R8

  AST_DROP_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(req_valid_i)); // R3

  AST_REPLAY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> busy_cnt_q < ($clog2(LANES+1))'(LANES - 1)); // R3

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |=> ready_o && !rsp_valid_o); // R9
endmodule

bind shared_scratch_mem ssm_checker #(.LANES(LANES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .ready_o    (ready_o),
  .rsp_valid_o(rsp_valid_o)
);

// File: tb/shared_scratch_mem_tb.sv
`timescale 1ns/1ps
module shared_scratch_mem_tb;
  localparam int LANES = 16;
  localparam int AW    = 14;
  localparam int DW    = 32;
  localparam int NT    = 8;
  // {stride, base, expected service cycles}
  localparam int TBL [NT][3] = '{
    '{1,  0,     1},
    '{1,  16368, 1},
    '{32, 0,     16},
    '{16, 3,     8},
    '{0,  777,   1},
    '{33, 5,     1},
    '{2,  64,    1},
    '{48, 1,     8}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic ready, rsp_valid;
  logic [LANES-1:0]       req_we = '0;
  logic [LANES*AW-1:0]    req_addr = '0;
  logic [LANES*DW-1:0]    req_wdata = '0;
  logic [LANES*DW-1:0]    rsp_rdata;

  int n_chk = 0, n_fail = 0;
  logic [31:0] model [int];

  always #2.5 clk = ~clk;

  shared_scratch_mem u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .ready_o(ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  logic [LANES-1:0][AW-1:0] a_v;
  logic [LANES-1:0][DW-1:0] w_v, r_v;

  // present one request for one accepting edge; junk=1 pokes writes during replay
  task automatic run_req(input logic [LANES-1:0] we, input bit junk, output int cyc);
    bit saw_ready;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a_v; req_wdata = w_v;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; cyc = 1; saw_ready = 0;
    while (!rsp_valid && cyc < 40) begin
      if (ready) saw_ready = 1;
      if (junk && cyc == 1) begin
        req_valid = 1'b1; req_we = '1;
        for (int l = 0; l < LANES; l++) begin
          req_addr[l*AW +: AW]  = AW'(5000 + l);
          req_wdata[l*DW +: DW] = 32'hDEAD_0000 + l;
        end
      end else req_valid = 1'b0;
      @(negedge clk); cyc++;
    end
    r_v = rsp_rdata;
    check(!saw_ready && ready, "R8 ready low during replay only", {31'd0, saw_ready}, 0);
    @(negedge clk);
    check(!rsp_valid, "R7 valid is one-cycle strobe", {31'd0, rsp_valid}, 0);
  endtask

  // reads see pre-request contents (R6), then writes apply lane-ascending so highest wins (R5)
  task automatic model_req(input logic [LANES-1:0] we, output logic [LANES-1:0][DW-1:0] exp);
    for (int l = 0; l < LANES; l++) exp[l] = model.exists(int'(a_v[l])) ? model[int'(a_v[l])] : 'x;
    for (int l = 0; l < LANES; l++) if (we[l]) model[int'(a_v[l])] = w_v[l];
  endtask

  initial begin
    int cyc;
    logic [LANES-1:0][DW-1:0] exp;
    string tag;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ready === 1'b1 && rsp_valid === 1'b0, "R9 reset state", {30'd0, ready, rsp_valid}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready === 1'b1 && rsp_valid === 1'b0, "R9 after reset", {30'd0, ready, rsp_valid}, 32'h2);

    for (int t = 0; t < NT; t++) begin
      tag = (TBL[t][0] == 0) ? "R4" : (TBL[t][2] == 1) ? "R2" : "R3";
      for (int l = 0; l < LANES; l++) begin
        a_v[l] = AW'(TBL[t][1] + l * TBL[t][0]);
        w_v[l] = {8'hA0 + 8'(t), 4'(l), 6'd0, a_v[l]};
      end
      model_req('1, exp);
      run_req('1, 0, cyc);
      check(cyc == TBL[t][2], {tag, " write cycles"}, cyc, TBL[t][2]);
      model_req('0, exp);
      run_req('0, 0, cyc);
      check(cyc == TBL[t][2], {tag, " read cycles"}, cyc, TBL[t][2]);
      for (int l = 0; l < LANES; l++)
        check(r_v[l] === exp[l], (t == 4) ? "R5 highest writer kept / R4 broadcast" : "R1 readback", r_v[l], exp[l]);
    end

    // R6: half the lanes read, half write the same address in one request
    for (int l = 0; l < LANES; l++) begin a_v[l] = 14'd100; w_v[l] = 32'hC0DE_0000 + l; end
    model_req(16'hFF00, exp);
    run_req(16'hFF00, 0, cyc);
    check(cyc == 1, "R6 mixed cycles", cyc, 1);
    for (int l = 0; l < 8; l++) check(r_v[l] === exp[l], "R6 read sees old word", r_v[l], exp[l]);
    model_req('0, exp);
    run_req('0, 0, cyc);
    check(r_v[0] === 32'hC0DE_000F, "R5 mixed highest writer", r_v[0], 32'hC0DE_000F);

    // R8: a request presented during replay is ignored
    for (int l = 0; l < LANES; l++) begin a_v[l] = AW'(5000 + l); w_v[l] = 32'h5000_0000 + l; end
    model_req('1, exp);
    run_req('1, 0, cyc);
    for (int l = 0; l < LANES; l++) a_v[l] = AW'(l * 32);
    model_req('0, exp);
    run_req('0, 1, cyc);
    check(cyc == 16, "R3 replay with junk present", cyc, 16);
    for (int l = 0; l < LANES; l++) a_v[l] = AW'(5000 + l);
    model_req('0, exp);
    run_req('0, 0, cyc);
    for (int l = 0; l < LANES; l++)
      check(r_v[l] === exp[l], "R8 busy request had no effect", r_v[l], exp[l]);

    summary();
  end
endmodule